// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block attributes a physical address to one of four memory ranks. Each rank has a bounds register giving the first and the last 16 MiB unit that the rank occupies. A typical use is to name the rank behind an address captured when a memory error is logged. A lookup is requested with a one-cycle strobe. One cycle later the block returns the winning rank index, a hit flag and a valid pulse.

The bounds registers are loaded through a small write port that takes an index and a data word. A status vector marks each rank as populated or not, and it follows the register contents at all times. A rank whose first and last unit are equal is treated as empty. Where populated ranges overlap, the lowest-numbered rank wins.

The address side is a plain strobe with no back-pressure. The block accepts a new lookup every cycle. Each result is valid for exactly one cycle and stays on the outputs until the next lookup replaces it. A consumer that cannot take a result in that cycle must hold its own copy.

Top module: `csd_cs_decoder`

## Requirements
- R1: After reset, res_vld, res_hit and res_cs are 0 and all populated bits are 0, because every bounds register resets to zero.
- R2: A cycle with cfg_we high loads cfg_wdata into the bounds register selected by cfg_idx. Bits 31:16 hold the first unit and bits 15:0 hold the last unit.
- R3: populated[i] is 1 exactly when the first and last units of rank i differ.
- R4: A populated rank matches an address when its first unit <= addr[39:24] <= its last unit. The last unit is inclusive, and addr[23:0] has no effect on the result.
- R5: An unpopulated rank never matches, even when addr[39:24] equals its first unit.
- R6: When several ranks match, res_cs is the lowest matching index.
- R7: When no rank matches, res_hit is 0 and res_cs is 0.
- R8: The cycle after addr_vld is sampled high, res_vld is 1 and carries that lookup's result. After a cycle with addr_vld low, res_vld is 0 and res_hit and res_cs keep their previous values.
- R9: A lookup sampled in the same cycle as a bounds write uses the bounds held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Bounds register write enable |
| cfg_idx | input | 2 | Index of the bounds register to write |
| cfg_wdata | input | 32 | Bounds value: first unit in 31:16, last unit in 15:0 |
| addr_vld | input | 1 | Lookup strobe |
| addr | input | 40 | Physical address to decode |
| res_vld | output | 1 | One-cycle pulse marking a fresh result |
| res_hit | output | 1 | Result matched a populated rank |
| res_cs | output | 2 | Winning rank index, 0 on a miss |
| populated | output | 4 | Per-rank populated status |

## Verification
A corrupt bounds register shows up in two places. It changes the populated bit in the cycle after the write, and it makes the next lookup near that rank's edges return the wrong index or hit flag. A broken priority order or comparator is only visible for addresses on range boundaries or in overlaps. For that reason the sweeps cover every unit value around each configured edge. A fault in the result stage shows one cycle after a strobe, as a missing valid pulse, or as a result that changes while no strobe is active.

// File: rtl/csd_pkg.sv
package csd_pkg;
  localparam int BND_W = 16;

  // one rank window, first unit in the upper half
  typedef struct packed {
    logic [BND_W-1:0] first_u;
    logic [BND_W-1:0] last_u;
  } csd_bnd_t;
endpackage

// File: rtl/csd_bounds_regs.sv
module csd_bounds_regs
  import csd_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = $clog2(NUM_CS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  csd_bnd_t              wr_data,
  output csd_bnd_t [NUM_CS-1:0] bnd_o
);
  csd_bnd_t [NUM_CS-1:0] bnd_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bnd_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        bnd_q[g] <= wr_data;
    end
  end

  assign bnd_o = bnd_q;
endmodule

// File: rtl/csd_range_cmp.sv
module csd_range_cmp
  import csd_pkg::*;
(
  input  csd_bnd_t         bnd,
  input  logic [BND_W-1:0] unit_idx,
  output logic             pop,
  output logic             hit
);
  // equal bounds mark an empty rank; last unit is inclusive
  assign pop = (bnd.first_u != bnd.last_u);
  assign hit = pop && (unit_idx >= bnd.first_u) && (unit_idx <= bnd.last_u);
endmodule

// File: rtl/csd_first_pick.sv
module csd_first_pick #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] req,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    // scan downward so the lowest set index is written last
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/csd_cs_decoder.sv
module csd_cs_decoder
  import csd_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter int UNIT_SHIFT = 24,
  parameter int ADDR_W     = UNIT_SHIFT + BND_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_CS)-1:0]  cfg_idx,
  input  logic [2*BND_W-1:0]         cfg_wdata,
  input  logic                       addr_vld,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       res_vld,
  output logic                       res_hit,
  output logic [$clog2(NUM_CS)-1:0]  res_cs,
  output logic [NUM_CS-1:0]          populated
);
  localparam int IDX_W = $clog2(NUM_CS);

  csd_bnd_t [NUM_CS-1:0] bnd;
  logic [BND_W-1:0]      unit_idx;
  logic [NUM_CS-1:0]     match;
  logic                  any_match;
  logic [IDX_W-1:0]      win_idx;
  logic                  unused_low;

  assign unit_idx   = addr[UNIT_SHIFT +: BND_W];
  assign unused_low = ^addr[UNIT_SHIFT-1:0];

  csd_bounds_regs #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (csd_bnd_t'(cfg_wdata)),
    .bnd_o   (bnd)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    csd_range_cmp cmp_i (
      .bnd      (bnd[g]),
      .unit_idx (unit_idx),
      .pop      (populated[g]),
      .hit      (match[g])
    );
  end

  csd_first_pick #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) pick_i (
    .req (match),
    .any (any_match),
    .idx (win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_cs  <= '0;
    end else begin
      res_vld <= addr_vld;
      if (addr_vld) begin
        res_hit <= any_match;
        res_cs  <= any_match ? win_idx : '0;
      end
    end
  end
endmodule

// File: rtl/csd_cs_decoder_chk.sv
module csd_cs_decoder_chk #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic [31:0]       cfg_wdata,
  input logic              addr_vld,
  input logic              res_vld,
  input logic              res_hit,
  input logic [IDX_W-1:0]  res_cs,
  input logic [NUM_CS-1:0] populated
);
  logic [NUM_CS-1:0] pop_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pop_d <= '0;
    else        pop_d <= populated;
  end

  a_r8_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |=> res_vld);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> !res_vld);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |=> ($stable(res_hit) && $stable(res_cs)));
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_hit) |-> (res_cs == '0));
  a_r5_hit_populated: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res_hit) |-> pop_d[res_cs]);
  a_r3_pop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (populated[$past(cfg_idx)] ==
                ($past(cfg_wdata[31:16]) != $past(cfg_wdata[15:0]))));
endmodule

bind csd_cs_decoder csd_cs_decoder_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_idx   (cfg_idx),
  .cfg_wdata (cfg_wdata),
  .addr_vld  (addr_vld),
  .res_vld   (res_vld),
  .res_hit   (res_hit),
  .res_cs    (res_cs),
  .populated (populated)
);

// File: tb/csd_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module csd_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        addr_vld = 1'b0;
  logic [39:0] addr = '0;
  logic        res_vld, res_hit;
  logic [1:0]  res_cs;
  logic [3:0]  populated;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [15:0] m_first [4];
  logic [15:0] m_last  [4];

  always #2.5 clk = ~clk;

  csd_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .addr_vld(addr_vld), .addr(addr),
    .res_vld(res_vld), .res_hit(res_hit), .res_cs(res_cs),
    .populated(populated)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference model: lowest populated rank whose window holds the unit
  function automatic logic [2:0] model(input logic [15:0] u);
    for (int i = 0; i < 4; i++) begin
      if (m_first[i] != m_last[i] && u >= m_first[i] && u <= m_last[i])
        return {1'b1, 2'(i)};
    end
    return 3'b000;
  endfunction

  function automatic logic [3:0] model_pop();
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = (m_first[i] != m_last[i]);
    return p;
  endfunction

  task automatic wr(input int idx, input logic [15:0] f, input logic [15:0] l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = {f, l};
    @(negedge clk);
    cfg_we = 1'b0;
    m_first[idx] = f; m_last[idx] = l;
    // R2 and R3: register contents reflected in populated status
    check(populated == model_pop(), "R3", 64'(populated), 64'(model_pop()));
  endtask

  task automatic lookup(input logic [15:0] u, input string req);
    logic [31:0] r;
    logic [2:0]  e;
    r = $urandom();
    e = model(u);
    @(negedge clk);
    addr_vld = 1'b1; addr = {u, r[23:0]};
    @(negedge clk);
    addr_vld = 1'b0;
    check(res_vld == 1'b1, "R8", 64'(res_vld), 64'd1);
    check({res_hit, res_cs} == e, req, 64'({res_hit, res_cs}), 64'(e));
  endtask

  task automatic sweep(input string req);
    for (int u = 0; u <= 20; u++) lookup(16'(u), req);
    lookup(16'hFFFF, req);
    lookup(16'hFFFE, req);
  endtask

  initial begin
    logic [2:0] held;
    logic [2:0] e_old;
    for (int i = 0; i < 4; i++) begin m_first[i] = '0; m_last[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(res_vld == 0 && res_hit == 0 && res_cs == 0, "R1",
          64'({res_vld, res_hit, res_cs}), 64'd0);
    check(populated == 4'b0, "R1", 64'(populated), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: empty configuration misses everywhere
    lookup(16'd0, "R7");
    lookup(16'd9, "R7");

    // config A: adjacent ranges, rank 2 empty (first==last, R5)
    wr(0, 16'd0, 16'd3);
    wr(1, 16'd4, 16'd7);
    wr(2, 16'd8, 16'd8);
    wr(3, 16'd8, 16'd15);
    sweep("R4");
    lookup(16'd8, "R5");

    // config B: overlapping ranges, lowest index wins (R6)
    wr(0, 16'd5, 16'd5);
    wr(1, 16'd2, 16'd10);
    wr(2, 16'd0, 16'd12);
    wr(3, 16'd10, 16'hFFFF);
    sweep("R6");
    lookup(16'd5, "R5");

    // config C: inverted bounds are populated but cover nothing
    wr(0, 16'd9, 16'd3);
    wr(1, 16'd14, 16'd18);
    wr(2, 16'd0, 16'd0);
    wr(3, 16'd19, 16'd19);
    sweep("R7");

    // R4: low address bits never matter
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addr_vld = 1'b1; addr = {16'd18, 24'hFFFFFF >> (3 * k)};
      @(negedge clk);
      addr_vld = 1'b0;
      check({res_hit, res_cs} == 3'b101, "R4", 64'({res_hit, res_cs}), 64'h5);
    end

    // R8: outputs hold while no strobe
    held = {res_hit, res_cs};
    @(negedge clk);
    addr = {16'd0, 24'd0};
    @(negedge clk);
    check(res_vld == 1'b0, "R8", 64'(res_vld), 64'd0);
    check({res_hit, res_cs} == held, "R8", 64'({res_hit, res_cs}), 64'(held));

    // R9: lookup and write in the same cycle sees the old bounds
    e_old = model(16'd15);
    @(negedge clk);
    addr_vld = 1'b1; addr = {16'd15, 24'h123456};
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_wdata = {16'd7, 16'd7};
    @(negedge clk);
    addr_vld = 1'b0; cfg_we = 1'b0;
    m_first[1] = 16'd7; m_last[1] = 16'd7;
    check({res_hit, res_cs} == e_old, "R9", 64'({res_hit, res_cs}), 64'(e_old));
    lookup(16'd15, "R9");
    check(populated == model_pop(), "R2", 64'(populated), 64'(model_pop()));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule